// File: doc/BRIEF.md
# Inter-processor interrupt mailbox controller

This block lets one processor raise a level interrupt on another through a small register window, and gives the two processors a set of mailbox words for handing over boot data to a secondary core. A sender sets bits in a pending-status register through a write-one-to-set port. The receiver sees its interrupt line go high, reads the status and acknowledges through a write-one-to-clear port. Only bits the receiver has enabled can ever be pending.

The register port is a plain synchronous 32-bit port: a select, a write enable, a word address, write data and registered read data. Every write, whatever its address, ends by masking the pending status with the enable register. Turning an enable bit off therefore throws away a pending bit rather than hiding it, and turning the enable back on does not bring it back.

Top module: `ipi_mbox_ctrl`

## Requirements
- R1: Reset clears the pending status, the enable register, every mailbox word, the read data and the interrupt output to zero.
- R2: A write to word address 2 (byte 0x08) ORs the write data into the pending status, and only bits whose enable bit is 1 survive the write.
- R3: A write to word address 3 (byte 0x0C) clears every pending bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: A write to word address 0 (byte 0x00, the status register) does not change the pending status. Reading word address 0 returns the status.
- R5: Word address 1 (byte 0x04) is a read/write enable register. After every write the pending status becomes status AND enable, so a pending bit whose enable is cleared is lost for good.
- R6: The interrupt output is high exactly when the pending status is non-zero. It changes one clock after the edge on which the status changed.
- R7: Word addresses 8 to 15 (bytes 0x20 to 0x3F) are eight independent read/write mailbox words.
- R8: Reads of word addresses 2, 3, 4 to 7 and 16 and above return zero. Writes to 4 to 7 and 16 and above change no mailbox, status or enable content.
- R9: Read data is registered and is valid on the clock after a read select. It holds its value on every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Register access select |
| wr_en | input | 1 | 1 = write, 0 = read, when sel is high |
| addr | input | WADDR_W (5) | Word address |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Registered read data |
| irq | output | 1 | Level interrupt, high while any status bit is pending |

## Verification
The two functions that meet in one cycle are a register write and the status masking it always triggers. This matters most when the write goes to the enable register while status bits are pending, or when a set write targets bits that are disabled. The bench sets bits, then drops one enable bit in a single write. It judges the result by reading the status back and watching the interrupt fall on the next clock. It then re-enables the bit and confirms the bit stays lost. A set write with the enable off is judged the same way: the status must read zero and the interrupt must stay low.

// File: rtl/ipi_mbox_pkg.sv
package ipi_mbox_pkg;

  // Kind of register a word address selects
  typedef enum logic [2:0] {
    RK_STATUS,
    RK_ENABLE,
    RK_SET,
    RK_CLEAR,
    RK_MBOX,
    RK_NONE
  } reg_kind_e;

  // Word offsets; software depends on these positions
  localparam int unsigned OFS_STATUS = 0;
  localparam int unsigned OFS_ENABLE = 1;
  localparam int unsigned OFS_SET    = 2;
  localparam int unsigned OFS_CLEAR  = 3;
  localparam int unsigned MBOX_BASE  = 8;

endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
  import ipi_mbox_pkg::*;
#(
  parameter int unsigned WADDR_W    = 5,
  parameter int unsigned MBOX_WORDS = 8,
  localparam int unsigned IDX_W = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
  input  logic [WADDR_W-1:0] addr,
  output reg_kind_e          kind,
  output logic [IDX_W-1:0]   mbox_idx
);

  logic [WADDR_W-1:0] rel;
  logic               in_mbox;

  always_comb begin
    rel      = addr - WADDR_W'(MBOX_BASE);
    in_mbox  = (addr >= WADDR_W'(MBOX_BASE)) && (rel < WADDR_W'(MBOX_WORDS));
    mbox_idx = rel[IDX_W-1:0];
    if (addr == WADDR_W'(OFS_STATUS))      kind = RK_STATUS;
    else if (addr == WADDR_W'(OFS_ENABLE)) kind = RK_ENABLE;
    else if (addr == WADDR_W'(OFS_SET))    kind = RK_SET;
    else if (addr == WADDR_W'(OFS_CLEAR))  kind = RK_CLEAR;
    else if (in_mbox)                      kind = RK_MBOX;
    else                                   kind = RK_NONE;
  end

endmodule

// File: rtl/ipi_pending.sv
module ipi_pending
  import ipi_mbox_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_go,
  input  reg_kind_e         kind,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] enable,
  output logic              irq
);

  logic [DATA_W-1:0] st_nx;
  logic [DATA_W-1:0] en_nx;

  always_comb begin
    st_nx = status;
    en_nx = enable;
    if (wr_go) begin
      case (kind)
        RK_SET:    st_nx = status | wdata;
        RK_CLEAR:  st_nx = status & ~wdata;
        RK_ENABLE: en_nx = wdata;
        default:   ;
      endcase
      // every write ends with the mask step, using the new enable
      st_nx = st_nx & en_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      enable <= '0;
      irq    <= 1'b0;
    end else begin
      status <= st_nx;
      enable <= en_nx;
      irq    <= |status;
    end
  end

endmodule

// File: rtl/ipi_mailbox_bank.sv
module ipi_mailbox_bank #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned MBOX_WORDS = 8,
  localparam int unsigned IDX_W = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_go,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_word
);

  logic [DATA_W-1:0]     words [MBOX_WORDS];
  logic [MBOX_WORDS-1:0] we_vec;

  for (genvar g = 0; g < MBOX_WORDS; g++) begin : g_we
    assign we_vec[g] = wr_go && (idx == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < MBOX_WORDS; i++) begin
      if (rst)            words[i] <= '0;
      else if (we_vec[i]) words[i] <= wdata;
    end
  end

  assign rd_word = words[idx];

endmodule

// File: rtl/ipi_mbox_ctrl.sv
module ipi_mbox_ctrl
  import ipi_mbox_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned WADDR_W    = 5,
  parameter int unsigned MBOX_WORDS = 8,
  localparam int unsigned IDX_W = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel,
  input  logic               wr_en,
  input  logic [WADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               irq
);

  reg_kind_e         kind;
  logic [IDX_W-1:0]  mbox_idx;
  logic [DATA_W-1:0] status;
  logic [DATA_W-1:0] enable;
  logic [DATA_W-1:0] mbox_rd;
  logic              wr_go;
  logic              rd_go;

  assign wr_go = sel & wr_en;
  assign rd_go = sel & ~wr_en;

  ipi_addr_decode #(.WADDR_W(WADDR_W), .MBOX_WORDS(MBOX_WORDS)) u_dec (
    .addr     (addr),
    .kind     (kind),
    .mbox_idx (mbox_idx)
  );

  ipi_pending #(.DATA_W(DATA_W)) u_pend (
    .clk    (clk),
    .rst    (rst),
    .wr_go  (wr_go),
    .kind   (kind),
    .wdata  (wdata),
    .status (status),
    .enable (enable),
    .irq    (irq)
  );

  ipi_mailbox_bank #(.DATA_W(DATA_W), .MBOX_WORDS(MBOX_WORDS)) u_mbox (
    .clk     (clk),
    .rst     (rst),
    .wr_go   (wr_go && (kind == RK_MBOX)),
    .idx     (mbox_idx),
    .wdata   (wdata),
    .rd_word (mbox_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_go) begin
      case (kind)
        RK_STATUS: rdata <= status;
        RK_ENABLE: rdata <= enable;
        RK_MBOX:   rdata <= mbox_rd;
        default:   rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/ipi_mbox_ctrl_chk.sv
module ipi_mbox_ctrl_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned WADDR_W = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               sel,
  input logic               wr_en,
  input logic [WADDR_W-1:0] addr,
  input logic [DATA_W-1:0]  rdata,
  input logic               irq
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && rdata == '0));

  assert_wo_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (sel && !wr_en && (addr == WADDR_W'(2) || addr == WADDR_W'(3))) |=> (rdata == '0));

  assert_gap_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (sel && !wr_en && addr >= WADDR_W'(4) && addr < WADDR_W'(8)) |=> (rdata == '0));

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(sel && !wr_en) |=> $stable(rdata));

  assert_irq_rise_after_set_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(sel && wr_en && addr == WADDR_W'(2), 2));

  assert_irq_fall_after_write_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(sel && wr_en, 2));

endmodule

bind ipi_mbox_ctrl ipi_mbox_ctrl_chk #(.DATA_W(DATA_W), .WADDR_W(WADDR_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .sel   (sel),
  .wr_en (wr_en),
  .addr  (addr),
  .rdata (rdata),
  .irq   (irq)
);

// File: tb/ipi_mbox_ctrl_tb.sv
module ipi_mbox_ctrl_tb;

  localparam int unsigned DATA_W  = 32;
  localparam int unsigned WADDR_W = 5;
  localparam int VEC_N = 18;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               sel = 1'b0;
  logic               wr_en = 1'b0;
  logic [WADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0]  wdata = '0;
  logic [DATA_W-1:0]  rdata;
  logic               irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ipi_mbox_ctrl u_dut (
    .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // {req[74:71], wr[70], addr[69:65], wdata[64:33], exp_rdata[32:1], exp_irq[0]}
  localparam logic [74:0] VEC [VEC_N] = '{
    {4'd1, 1'b0, 5'd0,  32'h0,        32'h0,        1'b0}, // R1 status zero
    {4'd5, 1'b1, 5'd1,  32'h000000FF, 32'h0,        1'b0}, // R5 enable low byte
    {4'd5, 1'b0, 5'd1,  32'h0,        32'h000000FF, 1'b0}, // R5 enable readback
    {4'd2, 1'b1, 5'd2,  32'h00000F05, 32'h0,        1'b1}, // R2 set, upper bits masked
    {4'd2, 1'b0, 5'd0,  32'h0,        32'h00000005, 1'b1}, // R2 status
    {4'd4, 1'b1, 5'd0,  32'hFFFFFFFF, 32'h0,        1'b1}, // R4 status write ignored
    {4'd4, 1'b0, 5'd0,  32'h0,        32'h00000005, 1'b1}, // R4 status unchanged
    {4'd8, 1'b0, 5'd2,  32'h0,        32'h0,        1'b1}, // R8 set reads zero
    {4'd3, 1'b1, 5'd3,  32'h00000001, 32'h0,        1'b1}, // R3 clear bit 0
    {4'd3, 1'b0, 5'd0,  32'h0,        32'h00000004, 1'b1}, // R3 status
    {4'd7, 1'b1, 5'd8,  32'hDEADBEEF, 32'h0,        1'b1}, // R7 first mailbox word
    {4'd7, 1'b1, 5'd15, 32'h12345678, 32'h0,        1'b1}, // R7 last mailbox word
    {4'd7, 1'b0, 5'd8,  32'h0,        32'hDEADBEEF, 1'b1}, // R7
    {4'd7, 1'b0, 5'd15, 32'h0,        32'h12345678, 1'b1}, // R7
    {4'd8, 1'b1, 5'd5,  32'h0000AAAA, 32'h0,        1'b1}, // R8 gap write
    {4'd8, 1'b0, 5'd5,  32'h0,        32'h0,        1'b1}, // R8 gap read
    {4'd6, 1'b1, 5'd3,  32'h00000004, 32'h0,        1'b0}, // R6 last bit cleared
    {4'd6, 1'b0, 5'd0,  32'h0,        32'h0,        1'b0}  // R6 status empty
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at a falling edge, the rising edge acts, rdata readable at the next falling edge
  task automatic access(input logic w, input logic [WADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    sel = 1'b1; wr_en = w; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr_en = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [74:0] v;
    repeat (3) @(negedge clk);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    check("R1 rdata after reset", rdata, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < VEC_N; i++) begin
      v = VEC[i];
      access(v[70], v[69:65], v[64:33]);
      if (!v[70]) check($sformatf("R%0d vec %0d rdata", v[74:71], i), rdata, v[32:1]);
      @(negedge clk);
      check($sformatf("R%0d vec %0d irq", v[74:71], i), {31'b0, irq}, {31'b0, v[0]});
    end

    // R2: set with the enable off leaves status zero and irq low
    access(1'b1, 5'd2, 32'h00000100);
    @(negedge clk);
    check("R2 disabled set irq", {31'b0, irq}, 32'h0);
    access(1'b0, 5'd0, 32'h0);
    check("R2 disabled set status", rdata, 32'h0);

    // R6: irq rises one clock after the status edge
    access(1'b1, 5'd2, 32'h00000002);
    check("R6 irq not yet", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R6 irq high", {31'b0, irq}, 32'h1);

    // R5: dropping the enable while pending loses the bit for good
    access(1'b1, 5'd1, 32'h000000FD);
    @(negedge clk);
    check("R5 irq after enable drop", {31'b0, irq}, 32'h0);
    access(1'b1, 5'd1, 32'h000000FF);
    @(negedge clk);
    check("R5 irq after re-enable", {31'b0, irq}, 32'h0);
    access(1'b0, 5'd0, 32'h0);
    check("R5 status stays lost", rdata, 32'h0);

    // R7: every mailbox word holds its own value
    for (int i = 0; i < 8; i++) access(1'b1, 5'(8 + i), 32'hA5000000 | (32'h1111 * i));
    for (int i = 0; i < 8; i++) begin
      access(1'b0, 5'(8 + i), 32'h0);
      check($sformatf("R7 mailbox word %0d", i), rdata, 32'hA5000000 | (32'h1111 * i));
    end

    // R8: beyond the region reads zero and writes nothing
    access(1'b1, 5'd24, 32'hFFFFFFFF);
    access(1'b1, 5'd16, 32'hFFFFFFFF);
    access(1'b0, 5'd24, 32'h0);
    check("R8 beyond-region read", rdata, 32'h0);
    access(1'b0, 5'd8, 32'h0);
    check("R8 mailbox untouched", rdata, 32'hA5000000);
    access(1'b0, 5'd1, 32'h0);
    check("R8 enable untouched", rdata, 32'h000000FF);

    // R9: rdata holds through a write and idle cycles
    access(1'b1, 5'd9, 32'h00000777);
    repeat (3) @(negedge clk);
    check("R9 rdata held", rdata, 32'h000000FF);

    // R1: reset in the middle of activity
    access(1'b1, 5'd2, 32'h00000001);
    @(negedge clk);
    check("R1 irq before reset", {31'b0, irq}, 32'h1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 irq cleared", {31'b0, irq}, 32'h0);
    access(1'b0, 5'd0, 32'h0);
    check("R1 status cleared", rdata, 32'h0);
    access(1'b0, 5'd1, 32'h0);
    check("R1 enable cleared", rdata, 32'h0);
    access(1'b0, 5'd9, 32'h0);
    check("R1 mailbox cleared", rdata, 32'h0);

    done = 1;
    summary();
    $finish;
  end

endmodule